// File: doc/BRIEF.md
# Deadzone PWM Duty Regulator

This block closes the digital side of a boost-converter voltage loop. A window comparator outside the block reports the output error as two bits: `req_up` asks for more duty and `req_dn` asks for less. Both low means the error is inside the dead band. An integrating up/down counter holds the duty command. A pulse-width modulator with a fixed period of `PERIOD` clock cycles turns that command into the switch-drive signal `pwm_out`. The switch is on for the first D cycles of each period, where D is the duty count.

The counter moves by one step at most once per switching period, on the last cycle of the period. It saturates at the limits `lim_lo` and `lim_hi`, which are driven from outside. A synchronous load port lets an external agent preset the counter, for example to resynchronise a redundant twin. The modulator takes a new duty value only at a period boundary. A pulse therefore never changes length while it is in progress. `duty_val` exposes the counter for readback.

The step decoder maps the comparator bits to four commands: CMD_HOLD (both low), CMD_RAISE (up only), CMD_LOWER (down only) and CMD_CLASH (both high, treated as hold). The output machine has two states, PW_HIGH and PW_LOW. It goes from PW_LOW to PW_HIGH when a period starts with a non-zero duty. It goes from PW_HIGH to PW_LOW when the phase reaches the duty count. It stays in PW_HIGH across the boundary when the duty is at least `PERIOD`, and stays in PW_LOW through a period whose duty is zero.

Top module: `dzpwm_regulator`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) sets the phase to 0 and `duty_val` to `RST_DUTY` (default 0). With the default, `pwm_out` is low after reset.
- R2: The switching period is exactly `PERIOD` cycles, with phase counting 0 to `PERIOD`-1. `pwm_out` is high in the phase-k cycle exactly when k < A, where A is the active duty of that period. A = 0 gives no pulse, and A >= `PERIOD` keeps the output high for the whole period.
- R3: In the last cycle of a period (phase `PERIOD`-1), with `load_en` low, `req_up`=1 and `req_dn`=0 raise `duty_val` by 1 on that edge. The result is capped at `lim_hi`: a value already >= `lim_hi` becomes `lim_hi`.
- R4: In the last cycle of a period, with `load_en` low, `req_dn`=1 and `req_up`=0 lower `duty_val` by 1. The result is floored at `lim_lo`: a value already <= `lim_lo` becomes `lim_lo`.
- R5: With both requests low in the last cycle of a period, `duty_val` holds.
- R6: With both requests high in the last cycle of a period (illegal input), `duty_val` holds.
- R7: Requests in any cycle other than the last cycle of a period have no effect on `duty_val`.
- R8: `load_en`=1 in any cycle sets `duty_val` to `load_val` on that edge, without clamping, and overrides any step in that cycle.
- R9: The active duty A is captured only at the period boundary, from the value `duty_val` takes on that edge. A load or a step therefore changes `pwm_out` only from the next period start onwards.
- R10: The counter never wraps. A raise at the maximum code, or a lower at zero, produces no carry or borrow past the limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_up | input | 1 | Comparator request: raise duty |
| req_dn | input | 1 | Comparator request: lower duty |
| lim_lo | input | DUTY_W | Lower saturation limit of the duty count |
| lim_hi | input | DUTY_W | Upper saturation limit of the duty count |
| load_en | input | 1 | Preset strobe for the duty counter |
| load_val | input | DUTY_W | Preset value |
| pwm_out | output | 1 | Switch-drive signal |
| duty_val | output | DUTY_W | Current duty count, for readback |

## Verification
A load is visible on `duty_val` one cycle after the edge that captures it. A step decided in the phase `PERIOD`-1 cycle appears on `duty_val` in the phase-0 cycle that follows. `pwm_out` is registered and shows the state for the current phase. A new duty therefore shapes `pwm_out` from the phase-0 cycle of the next period, and a mid-period load does not reach `pwm_out` until the period after that boundary. The bench drives inputs and samples outputs on the falling edge. It advances a bench reference of phase, counter and active duty by one cycle for every rising edge, so each comparison is made in exactly the cycle the requirement places the result.

// File: rtl/dzpwm_pkg.sv
package dzpwm_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD  = 2'd0,
        CMD_RAISE = 2'd1,
        CMD_LOWER = 2'd2,
        CMD_CLASH = 2'd3
    } step_cmd_e;

    typedef enum logic {
        PW_LOW  = 1'b0,
        PW_HIGH = 1'b1
    } pwm_state_e;

endpackage

// File: rtl/dzpwm_cmd_decode.sv
module dzpwm_cmd_decode
    import dzpwm_pkg::*;
(
    input  logic      req_up,
    input  logic      req_dn,
    output step_cmd_e cmd
);

    always_comb begin
        unique case ({req_up, req_dn})
            2'b10:   cmd = CMD_RAISE;
            2'b01:   cmd = CMD_LOWER;
            2'b11:   cmd = CMD_CLASH;
            default: cmd = CMD_HOLD;
        endcase
    end

endmodule

// File: rtl/dzpwm_duty_counter.sv
module dzpwm_duty_counter
    import dzpwm_pkg::*;
#(
    parameter int DUTY_W   = 8,
    parameter int RST_DUTY = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  step_cmd_e         cmd,
    input  logic              load_en,
    input  logic [DUTY_W-1:0] load_val,
    input  logic [DUTY_W-1:0] lim_lo,
    input  logic [DUTY_W-1:0] lim_hi,
    output logic [DUTY_W-1:0] duty_q,
    output logic [DUTY_W-1:0] duty_nxt
);

    localparam logic [DUTY_W-1:0] DUTY_INIT = DUTY_W'(RST_DUTY);
    localparam logic [DUTY_W-1:0] ONE       = DUTY_W'(1);

    logic [DUTY_W-1:0] stepped;

    always_comb begin
        unique case (cmd)
            CMD_RAISE: stepped = (duty_q >= lim_hi) ? lim_hi : duty_q + ONE;
            CMD_LOWER: stepped = (duty_q <= lim_lo) ? lim_lo : duty_q - ONE;
            CMD_CLASH: stepped = duty_q;
            default:   stepped = duty_q;
        endcase
    end

    always_comb begin
        if (load_en)   duty_nxt = load_val;
        else if (tick) duty_nxt = stepped;
        else           duty_nxt = duty_q;
    end

    always_ff @(posedge clk) begin
        if (rst) duty_q <= DUTY_INIT;
        else     duty_q <= duty_nxt;
    end

    // R5: dead band holds the count
    p_deadband_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en && cmd == CMD_HOLD) |=> $stable(duty_q));

    // R6: conflicting requests hold the count
    p_clash_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en && cmd == CMD_CLASH) |=> $stable(duty_q));

    // R7: no movement away from the period boundary
    p_mid_period_r7: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load_en) |=> $stable(duty_q));

    // R8: preset lands on the next edge
    p_load_r8: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (duty_q == $past(load_val)));

    // R3: raise at or above the ceiling pins to the ceiling
    p_cap_hi_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en && cmd == CMD_RAISE && duty_q >= lim_hi)
        |=> (duty_q == $past(lim_hi)));

    // R10: a raise below the ceiling never wraps to a smaller value
    p_no_wrap_up_r10: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en && cmd == CMD_RAISE && duty_q < lim_hi)
        |=> (duty_q > $past(duty_q)));

    // R10: a lower above the floor never wraps to a larger value
    p_no_wrap_dn_r10: assert property (@(posedge clk) disable iff (rst)
        (tick && !load_en && cmd == CMD_LOWER && duty_q > lim_lo)
        |=> (duty_q < $past(duty_q)));

endmodule

// File: rtl/dzpwm_pwm_engine.sv
module dzpwm_pwm_engine
    import dzpwm_pkg::*;
#(
    parameter int PERIOD   = 64,
    parameter int DUTY_W   = 8,
    parameter int RST_DUTY = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty_nxt,
    output logic              tick,
    output logic              pwm_out
);

    localparam int PH_W  = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam int CMP_W = ((PH_W > DUTY_W) ? PH_W : DUTY_W) + 1;
    localparam logic [PH_W-1:0]   PH_LAST   = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0]   PH_ONE    = PH_W'(1);
    localparam logic [DUTY_W-1:0] DUTY_INIT = DUTY_W'(RST_DUTY);
    localparam pwm_state_e        ST_INIT   = (RST_DUTY > 0) ? PW_HIGH : PW_LOW;

    logic [PH_W-1:0]   phase_q, phase_nxt;
    logic [DUTY_W-1:0] act_q, act_nxt;
    pwm_state_e        state_q, state_nxt;

    assign tick = (phase_q == PH_LAST);

    always_comb begin
        phase_nxt = tick ? '0 : phase_q + PH_ONE;
        act_nxt   = tick ? duty_nxt : act_q;
    end

    // next-state logic
    always_comb begin
        unique case (state_q)
            PW_HIGH: state_nxt = (CMP_W'(phase_nxt) < CMP_W'(act_nxt)) ? PW_HIGH : PW_LOW;
            PW_LOW:  state_nxt = (CMP_W'(phase_nxt) < CMP_W'(act_nxt)) ? PW_HIGH : PW_LOW;
            default: state_nxt = PW_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            act_q   <= DUTY_INIT;
            state_q <= ST_INIT;
        end else begin
            phase_q <= phase_nxt;
            act_q   <= act_nxt;
            state_q <= state_nxt;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            PW_HIGH: pwm_out = 1'b1;
            PW_LOW:  pwm_out = 1'b0;
            default: pwm_out = 1'b0;
        endcase
    end

    // R2: period wraps after PERIOD cycles
    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (phase_q == '0));

    // R2: zero active duty never drives the switch
    p_zero_duty_r2: assert property (@(posedge clk) disable iff (rst)
        (act_q == '0) |-> !pwm_out);

    // R2: a non-zero duty starts each period with the switch on
    p_pulse_start_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && duty_nxt != '0) |=> pwm_out);

    // R9: active duty is frozen inside a period
    p_act_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(act_q));

endmodule

// File: rtl/dzpwm_regulator.sv
module dzpwm_regulator
    import dzpwm_pkg::*;
#(
    parameter int PERIOD   = 64,
    parameter int DUTY_W   = 8,
    parameter int RST_DUTY = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_up,
    input  logic              req_dn,
    input  logic [DUTY_W-1:0] lim_lo,
    input  logic [DUTY_W-1:0] lim_hi,
    input  logic              load_en,
    input  logic [DUTY_W-1:0] load_val,
    output logic              pwm_out,
    output logic [DUTY_W-1:0] duty_val
);

    step_cmd_e         cmd;
    logic              tick;
    logic [DUTY_W-1:0] duty_nxt;

    dzpwm_cmd_decode u_decode (
        .req_up (req_up),
        .req_dn (req_dn),
        .cmd    (cmd)
    );

    dzpwm_duty_counter #(
        .DUTY_W   (DUTY_W),
        .RST_DUTY (RST_DUTY)
    ) u_counter (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cmd      (cmd),
        .load_en  (load_en),
        .load_val (load_val),
        .lim_lo   (lim_lo),
        .lim_hi   (lim_hi),
        .duty_q   (duty_val),
        .duty_nxt (duty_nxt)
    );

    dzpwm_pwm_engine #(
        .PERIOD   (PERIOD),
        .DUTY_W   (DUTY_W),
        .RST_DUTY (RST_DUTY)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .duty_nxt (duty_nxt),
        .tick     (tick),
        .pwm_out  (pwm_out)
    );

    // R1: reset leaves the switch off with the default reset duty
    p_reset_r1: assert property (@(posedge clk)
        (rst && RST_DUTY == 0) |=> (!pwm_out && duty_val == '0));

endmodule

// File: tb/dzpwm_regulator_tb.sv
module dzpwm_regulator_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PERIOD     = 12;
    localparam int DUTY_W     = 5;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_up = 1'b0, req_dn = 1'b0, load_en = 1'b0;
    logic [DUTY_W-1:0] lim_lo = 5'd3, lim_hi = 5'd9, load_val = '0;
    logic              pwm_out;
    logic [DUTY_W-1:0] duty_val;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int m_ph   = 0;
    int m_duty = 0;
    int m_act  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dzpwm_regulator #(.PERIOD(PERIOD), .DUTY_W(DUTY_W), .RST_DUTY(0)) u_dut (
        .clk(clk), .rst(rst), .req_up(req_up), .req_dn(req_dn),
        .lim_lo(lim_lo), .lim_hi(lim_hi), .load_en(load_en),
        .load_val(load_val), .pwm_out(pwm_out), .duty_val(duty_val)
    );

    function automatic int exp_next(int d, bit up, bit dn, bit ld, int lv,
                                    bit last, int lo, int hi);
        if (ld) return lv;
        if (!last) return d;
        if (up && !dn) return (d >= hi) ? hi : d + 1;
        if (dn && !up) return (d <= lo) ? lo : d - 1;
        return d;
    endfunction

    function automatic bit exp_pwm(int ph, int act);
        return ph < act;
    endfunction

    task automatic check(string tag, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cyc(string tag, bit up, bit dn, bit ld, int lv);
        int nd;
        req_up = up; req_dn = dn; load_en = ld; load_val = DUTY_W'(lv);
        nd = exp_next(m_duty, up, dn, ld, lv, m_ph == PERIOD-1,
                      int'(lim_lo), int'(lim_hi));
        if (m_ph == PERIOD-1) begin
            m_ph  = 0;
            m_act = nd;
        end else begin
            m_ph++;
        end
        m_duty = nd;
        @(posedge clk);
        @(negedge clk);
        check({tag, " duty"}, int'(duty_val), m_duty);
        check({tag, " pwm"}, int'(pwm_out), int'(exp_pwm(m_ph, m_act)));
    endtask

    task automatic to_last(string tag);
        while (m_ph != PERIOD-1) cyc(tag, 1'b0, 1'b0, 1'b0, 0);
    endtask

    initial begin
        process::self().srandom(32'd1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 duty", int'(duty_val), 0);
        check("R1 pwm", int'(pwm_out), 0);
        rst = 1'b0;

        // R2: zero duty gives no pulse over a full period
        for (int i = 0; i < PERIOD; i++) cyc("R2 zero", 1'b0, 1'b0, 1'b0, 0);

        // R8: preset mid-period, R9: pwm ignores it until boundary
        cyc("R8 load", 1'b0, 1'b0, 1'b1, 5);
        to_last("R9 frozen");
        for (int i = 0; i < PERIOD; i++) cyc("R2 shape", 1'b0, 1'b0, 1'b0, 0);

        // R3: raise up to the ceiling (9), R10 pinned there
        for (int k = 0; k < 6; k++) begin
            to_last("R7 idle");
            cyc("R3 raise", 1'b1, 1'b0, 1'b0, 0);
        end
        // R4: lower down to the floor (3)
        for (int k = 0; k < 8; k++) begin
            to_last("R7 idle");
            cyc("R4 lower", 1'b0, 1'b1, 1'b0, 0);
        end
        // R6: clash holds
        to_last("R7 idle");
        cyc("R6 clash", 1'b1, 1'b1, 1'b0, 0);
        // R5: dead band holds
        cyc("R5 hold", 1'b0, 1'b0, 1'b0, 0);
        // R7: requests everywhere except the last cycle
        while (m_ph != PERIOD-1) cyc("R7 ignored", 1'b1, 1'b0, 1'b0, 0);
        cyc("R5 deadband", 1'b0, 1'b0, 1'b0, 0);

        // R8: load beats a step in the boundary cycle
        to_last("R8 prep");
        cyc("R8 override", 1'b1, 1'b0, 1'b1, 7);

        // R2: duty above the period keeps the switch on
        lim_hi = 5'd31;
        cyc("R8 big", 1'b0, 1'b0, 1'b1, 20);
        to_last("R2 prep");
        for (int i = 0; i < PERIOD; i++) cyc("R2 full", 1'b0, 1'b0, 1'b0, 0);

        // R10: extremes of the code range
        cyc("R10 top", 1'b0, 1'b0, 1'b1, 31);
        to_last("R10 prep");
        cyc("R10 up", 1'b1, 1'b0, 1'b0, 0);
        lim_lo = 5'd0;
        cyc("R10 zero", 1'b0, 1'b0, 1'b1, 0);
        to_last("R10 prep");
        cyc("R10 dn", 1'b0, 1'b1, 1'b0, 0);
        lim_lo = 5'd3; lim_hi = 5'd9;

        // random mix
        for (int i = 0; i < 1500; i++) begin
            int r = int'($urandom_range(0, 99));
            bit up = (r < 40) || (r >= 95);
            bit dn = (r >= 40 && r < 75) || (r >= 95);
            bit ld = ($urandom_range(0, 49) == 0);
            cyc("R2 random", up, dn, ld, int'($urandom_range(0, 15)));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule